// File: doc/BRIEF.md
# Noise-Scaled Stochastic Stream Generator

This block turns one received channel symbol into a stochastic bit stream for a bit-serial iterative decoder. On a load strobe the signed fixed-point symbol is multiplied by a fixed constant and arithmetically shifted to give a scaled log-likelihood ratio. That ratio is clamped to the range a small table covers, and the table gives a probability word of `PROB_W` bits. The word is held in a register until the next load.

Every clock the held probability is compared with a pseudo-random word supplied by a shared source, such as an LFSR or a short table of stored words read in a cycle. A registered stream bit comes out of the compare. The scaling constant stands for 4a/Y, with Y the largest symbol magnitude and a a tuning constant. Because the noise term cancels in that product, the block has no noise-level or SNR input.

Top module: `stoch_stream_gen`

## Requirements
- R1: After reset, and until the first load, the probability register is zero, so `bit_o` is 0 for every random word.
- R2: The unclamped table index is floor(`sym_i` × `SCALE` / 2^`SCALE_SHIFT`), where `sym_i` is a two's-complement number. Its sign always matches the sign of `sym_i`.
- R3: The index is clamped to the interval [-2^(`LUT_K`-1), 2^(`LUT_K`-1)-1]. The defaults give [-16, 15].
- R4: The table entry for index i is round(2^`PROB_W` / (1 + e^(-i/2^`LLR_FRAC`))), capped at 2^`PROB_W`-1. Index 0 therefore maps to exactly half scale.
- R5: `bit_o` is registered. After each rising edge it equals 1 when the held probability, read as unsigned, is greater than the `rnd_i` value at that edge, and 0 when it is less.
- R6: When the held probability equals `rnd_i`, the next `bit_o` is 0.
- R7: While `load_i` is low, `sym_i` has no effect. The held probability, and so the stream, stays the same.
- R8: In the cycle in which a load is taken, the compare still uses the probability held before that load. The new value first affects `bit_o` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| load_i | input | 1 | Captures the probability for `sym_i` at the next rising edge |
| sym_i | input | SYM_W | Received symbol, signed fixed point |
| rnd_i | input | PROB_W | Uniform pseudo-random word, a new value each cycle |
| bit_o | output | 1 | Stochastic stream bit |

## Verification
A load taken at rising edge t changes the held probability at t. The first stream bit that depends on the new probability appears after edge t+1, and the bit after edge t itself still reflects the old probability. Each stream bit therefore depends only on the `rnd_i` value present at the edge just before it. The bench changes inputs on the falling edge and reads `bit_o` one nanosecond after the following rising edge. It sweeps every symbol and, for each one, every random word, so each table entry appears as an exact threshold. The compare at the load edge itself is also checked against the probability that was held before the load.

// File: rtl/stsg_pkg.sv
package stsg_pkg;

  // Logistic map of a fixed-point LLR index onto an unsigned probability word.
  function automatic int unsigned logistic_word(int idx, int frac_bits, int prob_bits);
    real llr;
    real full;
    real p;
    int unsigned v;
    llr  = real'(idx) / real'(1 << frac_bits);
    full = real'(1 << prob_bits);
    p    = full / (1.0 + $exp(-llr));
    v    = int'($rtoi(p + 0.5));
    if (v > (1 << prob_bits) - 1) v = (1 << prob_bits) - 1;
    return v;
  endfunction

endpackage

// File: rtl/stsg_scaler.sv
module stsg_scaler #(
  parameter int SYM_W       = 8,
  parameter int LUT_K       = 5,
  parameter int SCALE       = 3,
  parameter int SCALE_SHIFT = 4
) (
  input  logic [SYM_W-1:0] sym_i,
  output logic [LUT_K-1:0] idx_o
);
  localparam int PROD_W = SYM_W + 16;
  localparam logic signed [PROD_W-1:0] IDX_MAX = PROD_W'((1 <<< (LUT_K - 1)) - 1);
  localparam logic signed [PROD_W-1:0] IDX_MIN = -PROD_W'(1 <<< (LUT_K - 1));

  logic signed [PROD_W-1:0] sym_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    sym_ext = PROD_W'($signed(sym_i));
    prod    = sym_ext * $signed(PROD_W'(SCALE));
    shifted = prod >>> SCALE_SHIFT;
    if (shifted > IDX_MAX)      idx_o = IDX_MAX[LUT_K-1:0];
    else if (shifted < IDX_MIN) idx_o = IDX_MIN[LUT_K-1:0];
    else                        idx_o = shifted[LUT_K-1:0];
  end

endmodule

// File: rtl/stsg_prob_lut.sv
module stsg_prob_lut
  import stsg_pkg::*;
#(
  parameter int LUT_K    = 5,
  parameter int PROB_W   = 8,
  parameter int LLR_FRAC = 2
) (
  input  logic [LUT_K-1:0]  idx_i,
  output logic [PROB_W-1:0] prob_o
);
  localparam int ENTRIES = 1 << LUT_K;

  logic [PROB_W-1:0] tbl [ENTRIES];

  // Entry i holds the two's-complement index i read as a signed LLR.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam int SIDX = (i >= ENTRIES / 2) ? i - ENTRIES : i;
    localparam int unsigned PVAL = logistic_word(SIDX, LLR_FRAC, PROB_W);
    assign tbl[i] = PVAL[PROB_W-1:0];
  end

  assign prob_o = tbl[idx_i];

endmodule

// File: rtl/stsg_cmp.sv
module stsg_cmp #(
  parameter int PROB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [PROB_W-1:0] prob_i,
  input  logic [PROB_W-1:0] rnd_i,
  output logic              bit_o
);
  logic bit_d;
  logic bit_q;

  always_comb begin
    bit_d = bit_q;
    if (en_i) bit_d = (prob_i > rnd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  assign bit_o = bit_q;

  // R6
  tie_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && prob_i == rnd_i) |=> !bit_q);

  // R5
  cmp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (bit_q == ($past(prob_i) > $past(rnd_i))));

endmodule

// File: rtl/stoch_stream_gen.sv
module stoch_stream_gen #(
  parameter int SYM_W       = 8,
  parameter int PROB_W      = 8,
  parameter int LUT_K       = 5,
  parameter int LLR_FRAC    = 2,
  parameter int SCALE       = 3,
  parameter int SCALE_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SYM_W-1:0]  sym_i,
  input  logic [PROB_W-1:0] rnd_i,
  output logic              bit_o
);
  localparam logic [PROB_W-1:0] HALF = PROB_W'(1 << (PROB_W - 1));

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [LUT_K-1:0]  idx_w;
  logic [PROB_W-1:0] lut_prob;
  logic [PROB_W-1:0] prob_d;
  logic [PROB_W-1:0] prob_q;

  // Reset asserts asynchronously and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  stsg_scaler #(
    .SYM_W(SYM_W), .LUT_K(LUT_K), .SCALE(SCALE), .SCALE_SHIFT(SCALE_SHIFT)
  ) u_scale (
    .sym_i(sym_i),
    .idx_o(idx_w)
  );

  stsg_prob_lut #(
    .LUT_K(LUT_K), .PROB_W(PROB_W), .LLR_FRAC(LLR_FRAC)
  ) u_lut (
    .idx_i (idx_w),
    .prob_o(lut_prob)
  );

  always_comb begin
    prob_d = prob_q;
    if (load_i) prob_d = lut_prob;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) prob_q <= '0;
    else             prob_q <= prob_d;
  end

  stsg_cmp #(.PROB_W(PROB_W)) u_cmp (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_i  (1'b1),
    .prob_i(prob_q),
    .rnd_i (rnd_i),
    .bit_o (bit_o)
  );

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !load_i |=> $stable(prob_q));

  // R1
  zero_prob_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prob_q == '0) |=> !bit_o);

  // R2
  scale_sign_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sym_i[SYM_W-1] == idx_w[LUT_K-1]);

  // R4
  lut_half_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_i |=> ((prob_q >= HALF) == !$past(idx_w[LUT_K-1])));

endmodule

// File: tb/sim_stoch_stream_gen.sv
module sim_stoch_stream_gen;
  localparam int SYM_W = 8, PROB_W = 8, LUT_K = 5, LLR_FRAC = 2;
  localparam int SCALE = 3, SCALE_SHIFT = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic load_i;
  logic [SYM_W-1:0] sym_i;
  logic [PROB_W-1:0] rnd_i;
  logic bit_o;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  stoch_stream_gen #(
    .SYM_W(SYM_W), .PROB_W(PROB_W), .LUT_K(LUT_K), .LLR_FRAC(LLR_FRAC),
    .SCALE(SCALE), .SCALE_SHIFT(SCALE_SHIFT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i),
    .sym_i(sym_i), .rnd_i(rnd_i), .bit_o(bit_o)
  );

  function automatic int idx_of(int s, output bit sat);
    int v;
    v = (s * SCALE) >>> SCALE_SHIFT;
    sat = 1'b0;
    if (v > (1 << (LUT_K - 1)) - 1) begin v = (1 << (LUT_K - 1)) - 1; sat = 1'b1; end
    if (v < -(1 << (LUT_K - 1)))    begin v = -(1 << (LUT_K - 1));    sat = 1'b1; end
    return v;
  endfunction

  function automatic int prob_of(int i);
    real p;
    int v;
    p = real'(1 << PROB_W) / (1.0 + $exp(-(real'(i) / real'(1 << LLR_FRAC))));
    v = $rtoi(p + 0.5);
    if (v > (1 << PROB_W) - 1) v = (1 << PROB_W) - 1;
    return v;
  endfunction

  task automatic chk(input logic exp_bit, input string tag, input int r, input int p);
    vectors++;
    if (bit_o !== exp_bit) begin
      errors++;
      $display("FAIL %s: rnd=%0d prob=%0d bit actual=%b expected=%b",
               tag, r, p, bit_o, exp_bit);
    end
  endtask

  // Apply one random word and check the bit that the following edge produces.
  task automatic apply(input int r, input int p, input string tag);
    @(negedge clk);
    rnd_i = PROB_W'(r);
    @(posedge clk);
    #1;
    chk(p > r, tag, r, p);
  endtask

  // Load a symbol; the edge that takes the load still compares the old probability (R8).
  task automatic load_sym(input int s, input int old_p);
    @(negedge clk);
    sym_i  = SYM_W'(s);
    load_i = 1'b1;
    rnd_i  = PROB_W'(100);
    @(posedge clk);
    #1;
    chk(old_p > 100, "R8", 100, old_p);
    @(negedge clk);
    load_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        errors++;
        $display("FAIL watchdog: cycles actual=%0d expected<=150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    int cur_p;
    string tag;
    bit sat;
    rst_n  = 1'b0;
    load_i = 1'b0;
    sym_i  = '0;
    rnd_i  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state gives an all-zero stream.
    apply(0, 0, "R1");
    apply(1, 0, "R1");
    apply(128, 0, "R1");
    apply(255, 0, "R1");
    cur_p = 0;

    // Every symbol, every random word (R2, R3, R4, R5, R6, R7).
    for (int s = -(1 << (SYM_W - 1)); s < (1 << (SYM_W - 1)); s++) begin
      int p;
      p = prob_of(idx_of(s, sat));
      load_sym(s, cur_p);
      cur_p = p;
      sym_i = SYM_W'(~s);  // R7: unloaded symbol changes must be ignored
      for (int r = 0; r < (1 << PROB_W); r++) begin
        if (p == r)   tag = "R6";
        else if (sat) tag = "R3,R5,R7";
        else          tag = "R2,R4,R5,R7";
        apply(r, p, tag);
      end
    end

    // R7: hold a low probability while the symbol input swings to its maximum.
    load_sym(-(1 << (SYM_W - 1)), cur_p);
    cur_p = prob_of(idx_of(-(1 << (SYM_W - 1)), sat));
    sym_i = SYM_W'((1 << (SYM_W - 1)) - 1);
    for (int r = 0; r < 64; r++) apply(r * 4, cur_p, "R7");

    // R4: index zero maps to exactly half scale.
    load_sym(0, cur_p);
    cur_p = prob_of(0);
    if (cur_p != (1 << (PROB_W - 1))) begin
      errors++;
      $display("FAIL R4: bench half-scale actual=%0d expected=%0d", cur_p, 1 << (PROB_W - 1));
    end
    apply((1 << (PROB_W - 1)) - 1, 1 << (PROB_W - 1), "R4");
    apply(1 << (PROB_W - 1), 1 << (PROB_W - 1), "R6");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule